// File: doc/BRIEF.md
# MMC Host Register and Interrupt Unit

This block is the processor-facing register file of a memory-card host controller. A simple single-cycle bus selects one 32-bit word per access by byte address. Behind the register file sit a command unit and a FIFO/data engine. The block connects to both through one-cycle strobes and plain level signals, and does none of their work itself. It stores the card power and clock settings, the command argument and command word, the response words captured from the command unit, the data timer, the transfer length and the data control byte. It also keeps a down-counting byte count for the current transfer.

Status is one 22-bit word. The low 11 bits are sticky events raised by the engines and cleared by software through a clear register. The upper 11 bits are live levels supplied by the engines. Two interrupt lines are formed from that word, each through its own mask. Reading the FIFO data window pops one word from the engine's FIFO and raises a hold that stops the data engine from refilling. The hold is released by the next read of status or of the FIFO word count. The card-detect and write-protect levels are passed straight through.

Top module: `mmcHostRegs`

## Requirements
- R1: After reset, every register reads zero, both interrupt lines are low, no strobe is active and the refill hold is low.
- R2: Word offsets are: 0x00 power, 0x04 clock, 0x08 argument, 0x0C command, 0x10 response index, 0x14/0x18/0x1C/0x20 response words 0 to 3, 0x24 data timer, 0x28 data length, 0x2C data control, 0x30 byte count, 0x34 status, 0x38 clear, 0x3C mask 0, 0x40 mask 1, 0x48 word count, and 0x80 to 0xBC the FIFO window. Power and clock keep 8 bits, data length 16 bits and data control 8 bits. Argument and data timer keep all 32 bits.
- R3: A write to 0x38 clears the sticky status bits (bits 10:0) that are set in bits 10:0 of the written value. An event raised in the same cycle as the clear write wins and leaves its bit set.
- R4: Status reads as {liveStatus, sticky} with the sticky events in bits 10:0. irq0 is high exactly when status AND mask 0 is nonzero. irq1 is formed the same way from mask 1.
- R5: Offset 0x48 reads (byte count + 3) >> 2.
- R6: A read of the FIFO window while the FIFO holds data returns fifoRdata, pulses fifoPop in that cycle and sets refillHold. The next read of 0x34 or 0x48 returns its normal value and clears refillHold.
- R7: Offsets 0xFE0 to 0xFFC read one identification byte per word, in this order: 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R8: A FIFO window read while fifoEmpty is high returns 0, does not pulse fifoPop and does not set refillHold. A FIFO window write while the byte count is zero does not pulse fifoPush.
- R9: A write to 0x2C with bit 0 set loads the byte count from the data length and pulses dataStart in the next cycle. Each byteStrobe decrements a nonzero count. dataDone clears bit 0 of data control.
- R10: A write to 0x0C with bit 10 set and bit 9 clear pulses cmdStart in the next cycle. If bit 9 is set, no pulse is produced. Bit 10 always reads back as 0. A respLoad pulse captures respCmdIn and the four words of respIn, with word i taken from bits 32i+31:32i.
- R11: Unmapped offsets read as zero, and writes to them change nothing.
- R12: cardDetect follows cardDetectIn and cardRo follows cardRoIn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| busSel | input | 1 | Access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| irq0 | output | 1 | Interrupt line 0 |
| irq1 | output | 1 | Interrupt line 1 |
| powerOut | output | 8 | Power register |
| clockOut | output | 8 | Clock register |
| timerOut | output | 32 | Data timer register |
| cmdStart | output | 1 | Command issue pulse |
| cmdWordOut | output | 11 | Stored command word |
| cmdArgOut | output | 32 | Command argument |
| respLoad | input | 1 | Capture response |
| respCmdIn | input | 6 | Response command index |
| respIn | input | 128 | Four response words |
| evtSet | input | 11 | Sticky status events |
| liveStatus | input | 11 | Live status bits 21:11 |
| dataStart | output | 1 | Data engine start pulse |
| dataCtrlOut | output | 8 | Data control register |
| dataCntOut | output | 16 | Remaining byte count |
| byteStrobe | input | 1 | One byte moved |
| dataDone | input | 1 | Data engine idle |
| fifoPush | output | 1 | Push bus word into FIFO |
| fifoWdata | output | 32 | Word to push |
| fifoPop | output | 1 | Pop FIFO head |
| fifoRdata | input | 32 | FIFO head word |
| fifoEmpty | input | 1 | FIFO empty |
| refillHold | output | 1 | Refill held off |
| cardDetectIn | input | 1 | Card present level |
| cardRoIn | input | 1 | Write-protect level |
| cardDetect | output | 1 | Card present out |
| cardRo | output | 1 | Write-protect out |

## Verification
Two sticky-status updates can land in the same cycle: a software write to the clear register, and an engine event on evtSet for an overlapping bit. The bench creates this case by driving evtSet during the clear-write cycle, with random values and a fixed seed. It then reads status back and compares it with (old & ~clear) | event. The interrupt lines are checked against both masks after the same update, so an event that the clear drops shows up both in the status read and on the interrupt lines.

// File: rtl/mmcRegPkg.sv
package mmcRegPkg;
  localparam int CMD_GO_BIT   = 10;
  localparam int CMD_WAIT_BIT = 9;
  localparam int CTRL_RUN_BIT = 0;

  typedef enum logic [4:0] {
    SEL_NONE, SEL_POWER, SEL_CLOCK, SEL_ARG, SEL_CMD, SEL_RESPCMD,
    SEL_RESP0, SEL_RESP1, SEL_RESP2, SEL_RESP3, SEL_TIMER, SEL_LEN,
    SEL_CTRL, SEL_CNT, SEL_STATUS, SEL_CLEAR, SEL_MASK0, SEL_MASK1,
    SEL_WORDCNT, SEL_FIFO, SEL_ID
  } regSel_e;

  typedef struct packed {
    regSel_e sel;
    logic    wrEn;
    logic    rdEn;
    logic    cmdGo;
    logic    dataGo;
    logic    fifoPush;
    logic    fifoPop;
    logic    holdRelease;
  } strobe_t;

  function automatic logic [7:0] idByte(input logic [2:0] idx);
    case (idx)
      3'd0: idByte = 8'h81;
      3'd1: idByte = 8'h11;
      3'd2: idByte = 8'h04;
      3'd3: idByte = 8'h00;
      3'd4: idByte = 8'h0D;
      3'd5: idByte = 8'hF0;
      3'd6: idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/mmcRegCtrl.sv
module mmcRegCtrl
  import mmcRegPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              fifoEmpty,
  input  logic              dataCntZero,
  output strobe_t           strb,
  output logic              refillHold
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [31:0] wIdx;
  regSel_e     selNow;
  logic        deferQ;

  always_comb begin
    wIdx = '0;
    wIdx[WIDX_W-1:0] = busAddr[ADDR_W-1:2];
    case (wIdx)
      32'h00: selNow = SEL_POWER;
      32'h01: selNow = SEL_CLOCK;
      32'h02: selNow = SEL_ARG;
      32'h03: selNow = SEL_CMD;
      32'h04: selNow = SEL_RESPCMD;
      32'h05: selNow = SEL_RESP0;
      32'h06: selNow = SEL_RESP1;
      32'h07: selNow = SEL_RESP2;
      32'h08: selNow = SEL_RESP3;
      32'h09: selNow = SEL_TIMER;
      32'h0A: selNow = SEL_LEN;
      32'h0B: selNow = SEL_CTRL;
      32'h0C: selNow = SEL_CNT;
      32'h0D: selNow = SEL_STATUS;
      32'h0E: selNow = SEL_CLEAR;
      32'h0F: selNow = SEL_MASK0;
      32'h10: selNow = SEL_MASK1;
      32'h12: selNow = SEL_WORDCNT;
      default: begin
        if (wIdx >= 32'h20 && wIdx <= 32'h2F)       selNow = SEL_FIFO;
        else if (wIdx >= 32'h3F8 && wIdx <= 32'h3FF) selNow = SEL_ID;
        else                                         selNow = SEL_NONE;
      end
    endcase
  end

  always_comb begin
    strb.sel         = busSel ? selNow : SEL_NONE;
    strb.wrEn        = busSel && busWrite;
    strb.rdEn        = busSel && !busWrite;
    strb.cmdGo       = strb.wrEn && (selNow == SEL_CMD) &&
                       busWdata[CMD_GO_BIT] && !busWdata[CMD_WAIT_BIT];
    strb.dataGo      = strb.wrEn && (selNow == SEL_CTRL) && busWdata[CTRL_RUN_BIT];
    strb.fifoPush    = strb.wrEn && (selNow == SEL_FIFO) && !dataCntZero;
    strb.fifoPop     = strb.rdEn && (selNow == SEL_FIFO) && !fifoEmpty;
    strb.holdRelease = strb.rdEn && ((selNow == SEL_STATUS) || (selNow == SEL_WORDCNT));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 deferQ <= 1'b0;
    else if (strb.fifoPop)     deferQ <= 1'b1;
    else if (strb.holdRelease) deferQ <= 1'b0;
  end

  assign refillHold = deferQ;

  // R6
  pop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && selNow == SEL_FIFO && !fifoEmpty) |=> refillHold);

  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refillHold && busSel && !busWrite && selNow == SEL_STATUS) |=> !refillHold);

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!refillHold && busSel && !busWrite && selNow == SEL_FIFO && fifoEmpty) |=> !refillHold);
endmodule

// File: rtl/mmcRegData.sv
module mmcRegData
  import mmcRegPkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int LEN_W    = 16,
  parameter int STICKY_W = 11,
  parameter int LIVE_W   = 11,
  parameter int CMD_W    = 11,
  parameter int IDX_W    = 6,
  parameter int RESP_N   = 4,
  parameter int NARROW_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strb,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [DATA_W-1:0]        busWdata,
  output logic [DATA_W-1:0]        busRdata,
  output logic                     irq0,
  output logic                     irq1,
  output logic [NARROW_W-1:0]      powerOut,
  output logic [NARROW_W-1:0]      clockOut,
  output logic [DATA_W-1:0]        timerOut,
  output logic                     cmdStart,
  output logic [CMD_W-1:0]         cmdWordOut,
  output logic [DATA_W-1:0]        cmdArgOut,
  input  logic                     respLoad,
  input  logic [IDX_W-1:0]         respCmdIn,
  input  logic [RESP_N*DATA_W-1:0] respIn,
  input  logic [STICKY_W-1:0]      evtSet,
  input  logic [LIVE_W-1:0]        liveStatus,
  output logic                     dataStart,
  output logic [NARROW_W-1:0]      dataCtrlOut,
  output logic [LEN_W-1:0]         dataCntOut,
  output logic                     dataCntZero,
  input  logic                     byteStrobe,
  input  logic                     dataDone,
  input  logic [DATA_W-1:0]        fifoRdata,
  input  logic                     fifoEmpty
);
  localparam int STAT_W = STICKY_W + LIVE_W;
  localparam int IRQ_N  = 2;

  logic [NARROW_W-1:0] powerQ, clockQ, ctrlQ;
  logic [DATA_W-1:0]   argQ, timerQ;
  logic [CMD_W-1:0]    cmdQ;
  logic [IDX_W-1:0]    respCmdQ;
  logic [DATA_W-1:0]   respQ [RESP_N];
  logic [LEN_W-1:0]    lenQ, cntQ;
  logic [STICKY_W-1:0] stickyQ;
  logic [STAT_W-1:0]   maskQ [IRQ_N];
  logic [STAT_W-1:0]   statusWord;
  logic [IRQ_N-1:0]    irqVec;
  logic                cmdStartQ, dataStartQ;
  logic [LEN_W:0]      cntRound;
  logic                wrClear;

  assign wrClear    = strb.wrEn && (strb.sel == SEL_CLEAR);
  assign statusWord = {liveStatus, stickyQ};

  // Configuration registers written from the bus
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      powerQ <= '0; clockQ <= '0; argQ <= '0; timerQ <= '0;
      lenQ   <= '0; cmdQ   <= '0;
    end else if (strb.wrEn) begin
      case (strb.sel)
        SEL_POWER: powerQ <= busWdata[NARROW_W-1:0];
        SEL_CLOCK: clockQ <= busWdata[NARROW_W-1:0];
        SEL_ARG:   argQ   <= busWdata;
        SEL_TIMER: timerQ <= busWdata;
        SEL_LEN:   lenQ   <= busWdata[LEN_W-1:0];
        SEL_CMD: begin
          cmdQ <= busWdata[CMD_W-1:0];
          cmdQ[CMD_GO_BIT] <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // Interrupt masks, one per line
  for (genvar m = 0; m < IRQ_N; m++) begin : gMask
    localparam regSel_e MSEL = (m == 0) ? SEL_MASK0 : SEL_MASK1;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   maskQ[m] <= '0;
      else if (strb.wrEn && strb.sel == MSEL)      maskQ[m] <= busWdata[STAT_W-1:0];
    end
    assign irqVec[m] = |(statusWord & maskQ[m]);
  end
  assign irq0 = irqVec[0];
  assign irq1 = irqVec[1];

  // Response capture
  for (genvar r = 0; r < RESP_N; r++) begin : gResp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         respQ[r] <= '0;
      else if (respLoad) respQ[r] <= respIn[r*DATA_W +: DATA_W];
    end
  end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         respCmdQ <= '0;
    else if (respLoad) respCmdQ <= respCmdIn;
  end

  // Sticky status: events win over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stickyQ <= '0;
    else       stickyQ <= (stickyQ & ~(wrClear ? busWdata[STICKY_W-1:0] : '0)) | evtSet;
  end

  // Data control and byte count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      cntQ  <= '0;
    end else begin
      if (strb.wrEn && strb.sel == SEL_CTRL) ctrlQ <= busWdata[NARROW_W-1:0];
      else if (dataDone)                     ctrlQ[CTRL_RUN_BIT] <= 1'b0;
      if (strb.dataGo)                       cntQ <= lenQ;
      else if (byteStrobe && cntQ != '0)     cntQ <= cntQ - 1'b1;
    end
  end

  // One-cycle start pulses toward the engines
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdStartQ  <= 1'b0;
      dataStartQ <= 1'b0;
    end else begin
      cmdStartQ  <= strb.cmdGo;
      dataStartQ <= strb.dataGo;
    end
  end

  assign cntRound = {1'b0, cntQ} + (LEN_W+1)'(3);

  // Read multiplexer
  always_comb begin
    busRdata = '0;
    if (strb.rdEn) begin
      case (strb.sel)
        SEL_POWER:   busRdata[NARROW_W-1:0] = powerQ;
        SEL_CLOCK:   busRdata[NARROW_W-1:0] = clockQ;
        SEL_ARG:     busRdata = argQ;
        SEL_CMD:     busRdata[CMD_W-1:0] = cmdQ;
        SEL_RESPCMD: busRdata[IDX_W-1:0] = respCmdQ;
        SEL_RESP0:   busRdata = respQ[0];
        SEL_RESP1:   busRdata = respQ[1];
        SEL_RESP2:   busRdata = respQ[2];
        SEL_RESP3:   busRdata = respQ[3];
        SEL_TIMER:   busRdata = timerQ;
        SEL_LEN:     busRdata[LEN_W-1:0] = lenQ;
        SEL_CTRL:    busRdata[NARROW_W-1:0] = ctrlQ;
        SEL_CNT:     busRdata[LEN_W-1:0] = cntQ;
        SEL_STATUS:  busRdata[STAT_W-1:0] = statusWord;
        SEL_MASK0:   busRdata[STAT_W-1:0] = maskQ[0];
        SEL_MASK1:   busRdata[STAT_W-1:0] = maskQ[1];
        SEL_WORDCNT: busRdata[LEN_W-2:0] = cntRound[LEN_W:2];
        SEL_FIFO:    busRdata = fifoEmpty ? '0 : fifoRdata;
        SEL_ID:      busRdata[7:0] = idByte(busAddr[4:2]);
        default:     busRdata = '0;
      endcase
    end
  end

  assign powerOut    = powerQ;
  assign clockOut    = clockQ;
  assign timerOut    = timerQ;
  assign cmdStart    = cmdStartQ;
  assign cmdWordOut  = cmdQ;
  assign cmdArgOut   = argQ;
  assign dataStart   = dataStartQ;
  assign dataCtrlOut = ctrlQ;
  assign dataCntOut  = cntQ;
  assign dataCntZero = (cntQ == '0);

  // R9
  data_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataGo |=> (dataCntOut == $past(lenQ)));

  // R9
  count_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.dataGo && byteStrobe && dataCntOut != '0) |=> (dataCntOut == $past(dataCntOut) - 1'b1));

  // R3
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrClear |=> ((stickyQ & $past(busWdata[STICKY_W-1:0]) & ~$past(evtSet)) == '0));

  // R10
  cmd_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |-> !cmdWordOut[CMD_GO_BIT]);
endmodule

// File: rtl/mmcHostRegs.sv
module mmcHostRegs
  import mmcRegPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         busSel,
  input  logic         busWrite,
  input  logic [11:0]  busAddr,
  input  logic [31:0]  busWdata,
  output logic [31:0]  busRdata,
  output logic         irq0,
  output logic         irq1,
  output logic [7:0]   powerOut,
  output logic [7:0]   clockOut,
  output logic [31:0]  timerOut,
  output logic         cmdStart,
  output logic [10:0]  cmdWordOut,
  output logic [31:0]  cmdArgOut,
  input  logic         respLoad,
  input  logic [5:0]   respCmdIn,
  input  logic [127:0] respIn,
  input  logic [10:0]  evtSet,
  input  logic [10:0]  liveStatus,
  output logic         dataStart,
  output logic [7:0]   dataCtrlOut,
  output logic [15:0]  dataCntOut,
  input  logic         byteStrobe,
  input  logic         dataDone,
  output logic         fifoPush,
  output logic [31:0]  fifoWdata,
  output logic         fifoPop,
  input  logic [31:0]  fifoRdata,
  input  logic         fifoEmpty,
  output logic         refillHold,
  input  logic         cardDetectIn,
  input  logic         cardRoIn,
  output logic         cardDetect,
  output logic         cardRo
);
  strobe_t strb;
  logic    dataCntZero;

  mmcRegCtrl #(.ADDR_W(12), .DATA_W(32)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .fifoEmpty(fifoEmpty),
    .dataCntZero(dataCntZero), .strb(strb), .refillHold(refillHold)
  );

  mmcRegData #(.ADDR_W(12), .DATA_W(32), .LEN_W(16)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq0(irq0), .irq1(irq1),
    .powerOut(powerOut), .clockOut(clockOut), .timerOut(timerOut),
    .cmdStart(cmdStart), .cmdWordOut(cmdWordOut), .cmdArgOut(cmdArgOut),
    .respLoad(respLoad), .respCmdIn(respCmdIn), .respIn(respIn),
    .evtSet(evtSet), .liveStatus(liveStatus), .dataStart(dataStart),
    .dataCtrlOut(dataCtrlOut), .dataCntOut(dataCntOut),
    .dataCntZero(dataCntZero), .byteStrobe(byteStrobe), .dataDone(dataDone),
    .fifoRdata(fifoRdata), .fifoEmpty(fifoEmpty)
  );

  assign fifoPush   = strb.fifoPush;
  assign fifoPop    = strb.fifoPop;
  assign fifoWdata  = busWdata;
  assign cardDetect = cardDetectIn;
  assign cardRo     = cardRoIn;
endmodule

// File: tb/mmcHostRegs_test.sv
`timescale 1ns/1ps
module mmcHostRegs_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 0, busWrite = 0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic irq0, irq1;
  logic [7:0] powerOut, clockOut, dataCtrlOut;
  logic [31:0] timerOut, cmdArgOut, fifoWdata;
  logic cmdStart, dataStart, fifoPush, fifoPop, refillHold, cardDetect, cardRo;
  logic [10:0] cmdWordOut;
  logic respLoad = 0;
  logic [5:0] respCmdIn = '0;
  logic [127:0] respIn = '0;
  logic [10:0] evtSet = '0, liveStatus = '0;
  logic [15:0] dataCntOut;
  logic byteStrobe = 0, dataDone = 0, fifoEmpty = 1;
  logic [31:0] fifoRdata = '0;
  logic cardDetectIn = 0, cardRoIn = 0;

  int nChecks = 0, nFails = 0;
  logic [10:0] mSticky = '0;
  logic [21:0] mMask [2];
  logic popSeen, pushSeen;

  always #10 clk = ~clk;

  mmcHostRegs uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    #1 pushSeen = fifoPush;
    @(negedge clk); busSel = 0; busWrite = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); busSel = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata; popSeen = fifoPop;
    @(negedge clk); busSel = 0;
  endtask

  task automatic pulseEvt(input logic [10:0] e);
    @(negedge clk); evtSet = e;
    @(negedge clk); evtSet = '0;
  endtask

  task automatic clrWithEvt(input logic [31:0] v, input logic [10:0] e);
    @(negedge clk); busSel = 1; busWrite = 1; busAddr = 12'h038; busWdata = v; evtSet = e;
    @(negedge clk); busSel = 0; busWrite = 0; evtSet = '0;
  endtask

  task automatic strobeBytes(input int n);
    @(negedge clk); byteStrobe = 1;
    repeat (n) @(negedge clk);
    byteStrobe = 0;
  endtask

  function automatic logic expIrq(input logic [10:0] live, input logic [10:0] st,
                                  input logic [21:0] m);
    return |({live, st} & m);
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] r;
    mMask[0] = '0; mMask[1] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    rd(12'h000, r); chk("R1 power", r, 0);
    rd(12'h034, r); chk("R1 status", r, 0);
    rd(12'h030, r); chk("R1 count", r, 0);
    rd(12'h040, r); chk("R1 mask1", r, 0);
    chk("R1 irq", {30'd0, irq1, irq0}, 0);
    chk("R1 hold", {31'd0, refillHold}, 0);

    // R2 widths and offsets
    wr(12'h000, 32'h1FF);      rd(12'h000, r); chk("R2 power", r, 32'hFF);
    wr(12'h004, 32'hABC);      rd(12'h004, r); chk("R2 clock", r, 32'hBC);
    wr(12'h008, 32'hDEADBEEF); rd(12'h008, r); chk("R2 arg", r, 32'hDEADBEEF);
    wr(12'h024, 32'h13572468); rd(12'h024, r); chk("R2 timer", r, 32'h13572468);
    wr(12'h028, 32'h12345);    rd(12'h028, r); chk("R2 length", r, 32'h2345);
    wr(12'h02C, 32'h1F2);      rd(12'h02C, r); chk("R2 ctrl", r, 32'hF2);

    // R11 unmapped
    wr(12'h044, 32'hFFFFFFFF); rd(12'h044, r); chk("R11 read 0x44", r, 0);
    wr(12'h100, 32'hFFFFFFFF); rd(12'h100, r); chk("R11 read 0x100", r, 0);
    rd(12'h000, r); chk("R11 power kept", r, 32'hFF);

    // R7 identification
    for (int i = 0; i < 8; i++) begin
      logic [7:0] ex [8];
      ex = '{8'h81, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      rd(12'hFE0 + 12'(i * 4), r); chk("R7 id byte", r, {24'd0, ex[i]});
    end

    // R10 command issue and response capture
    wr(12'h00C, 32'h452);
    chk("R10 cmdStart", {31'd0, cmdStart}, 1);
    rd(12'h00C, r); chk("R10 go bit clear", r, 32'h052);
    wr(12'h00C, 32'h652);
    chk("R10 pending no start", {31'd0, cmdStart}, 0);
    @(negedge clk); respLoad = 1; respCmdIn = 6'h2A;
    respIn = {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111};
    @(negedge clk); respLoad = 0;
    rd(12'h010, r); chk("R10 resp index", r, 32'h2A);
    rd(12'h014, r); chk("R10 resp0", r, 32'h11111111);
    rd(12'h020, r); chk("R10 resp3", r, 32'h44444444);

    // R9 data start, count, done; R5 word count
    wr(12'h028, 32'h000A);
    wr(12'h02C, 32'h3);
    chk("R9 dataStart", {31'd0, dataStart}, 1);
    rd(12'h030, r); chk("R9 count loaded", r, 10);
    rd(12'h048, r); chk("R5 word count 10", r, 3);
    strobeBytes(3);
    rd(12'h030, r); chk("R9 count decrement", r, 7);
    rd(12'h048, r); chk("R5 word count 7", r, 2);
    @(negedge clk); dataDone = 1; @(negedge clk); dataDone = 0;
    rd(12'h02C, r); chk("R9 done clears run", r, 32'h2);

    // R8 FIFO write with count nonzero, empty read
    wr(12'h080, 32'h55AA55AA); chk("R8 push forwarded", {31'd0, pushSeen}, 1);
    chk("R8 push data", fifoWdata, 32'h55AA55AA);
    fifoEmpty = 1;
    rd(12'h0BC, r); chk("R8 empty read data", r, 0);
    chk("R8 empty no pop", {31'd0, popSeen}, 0);
    chk("R8 empty no hold", {31'd0, refillHold}, 0);
    strobeBytes(8);
    rd(12'h030, r); chk("R9 count floor", r, 0);
    rd(12'h048, r); chk("R5 word count 0", r, 0);
    wr(12'h084, 32'h1); chk("R8 push dropped", {31'd0, pushSeen}, 0);

    // R6 pop, hold, release by status and by word count
    fifoEmpty = 0; fifoRdata = 32'hCAFE0001;
    rd(12'h090, r); chk("R6 pop data", r, 32'hCAFE0001);
    chk("R6 pop pulse", {31'd0, popSeen}, 1);
    chk("R6 hold set", {31'd0, refillHold}, 1);
    rd(12'h000, r); chk("R6 hold kept by other read", {31'd0, refillHold}, 1);
    rd(12'h034, r); chk("R6 status value", r, {10'd0, liveStatus, mSticky});
    chk("R6 hold released by status", {31'd0, refillHold}, 0);
    rd(12'h080, r);
    rd(12'h048, r); chk("R6 word count value", r, 0);
    chk("R6 hold released by count", {31'd0, refillHold}, 0);
    fifoEmpty = 1;

    // R12 pass-through
    cardDetectIn = 1; cardRoIn = 0; #1;
    chk("R12 detect", {30'd0, cardDetect, cardRo}, 32'h2);
    cardDetectIn = 0; cardRoIn = 1; #1;
    chk("R12 read-only", {30'd0, cardDetect, cardRo}, 32'h1);

    // R3 / R4 random status, clear, mask traffic with same-cycle collisions
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 80; i++) begin
      int op;
      logic [31:0] v;
      logic [10:0] e;
      op = $urandom_range(0, 3);
      v = $urandom();
      e = 11'($urandom());
      case (op)
        0: begin pulseEvt(e); mSticky = mSticky | e; end
        1: begin wr(12'h038, v); mSticky = mSticky & ~v[10:0]; end
        2: begin
          if (v[31]) begin wr(12'h040, v); mMask[1] = v[21:0]; end
          else       begin wr(12'h03C, v); mMask[0] = v[21:0]; end
        end
        default: begin clrWithEvt(v, e); mSticky = (mSticky & ~v[10:0]) | e; end
      endcase
      liveStatus = ($urandom_range(0, 3) == 0) ? 11'($urandom()) : '0;
      #1;
      chk("R4 irq0", {31'd0, irq0}, {31'd0, expIrq(liveStatus, mSticky, mMask[0])});
      chk("R4 irq1", {31'd0, irq1}, {31'd0, expIrq(liveStatus, mSticky, mMask[1])});
      rd(12'h034, r); chk("R3 status after update", r, {10'd0, liveStatus, mSticky});
    end

    // R3 directed: clear everything, event on same bit survives
    pulseEvt(11'h7FF); mSticky = 11'h7FF;
    clrWithEvt(32'hFFFFFFFF, 11'h004);
    rd(12'h034, r); chk("R3 event beats clear", r, {10'd0, liveStatus, 11'h004});

    summary();
    $finish;
  end
endmodule